// File: doc/BRIEF.md
# Aging-Register LRU Victim Selector

This block approximates least-recently-used replacement over a fixed set of memory frames. Each frame owns a small aging register that serves as a compressed history of recent use. A reference event names one frame. On that event every aging register moves one bit toward its least significant end, and the named frame gets a 1 in its most significant bit. A frame that has been used recently therefore holds a large value, and a frame that has sat idle decays toward zero.

When the surrounding replacement logic needs a frame to evict, it raises a request. The block searches for the smallest aging value among all frames. If several frames tie, it picks the lowest-numbered one. It registers that frame number and presents it one cycle later. A separate fill strobe initialises the register of a frame that has just been loaded with a new page. The fill sets only the most significant bit, so a fresh page counts as just used and has no older history.

Top module: `aging_lru_picker`

## Requirements
- R1: Reset clears every aging register to zero and holds `victimValid` low and `victimFrame` at 0. A request right after reset therefore returns frame 0.
- R2: In a cycle with `refValid` high, the aging register of every frame except the one being filled moves right by one bit, and a 0 enters at its most significant bit unless R3 applies. With neither `refValid` nor `fillValid` high, all registers keep their values.
- R3: In a cycle with `refValid` high, the register of frame `refFrame` also gets 1 in its most significant bit, at the same time as its shift.
- R4: In a cycle with `fillValid` high, the register of frame `fillFrame` becomes most-significant-bit-only (binary 1 followed by zeros). This overrides any reference to the same frame in that cycle. Other frames still shift if `refValid` is high.
- R5: The returned frame number is one whose aging value, as an unsigned number, is no greater than that of any other frame.
- R6: When several frames share the smallest value, the lowest-numbered of them is returned.
- R7: `victimValid` is high for exactly one cycle, in the cycle after the one in which `victimReq` was sampled high. The result reflects the aging values as they stood before any reference or fill in the request cycle. `victimFrame` holds its last result between requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A reference event happens this cycle |
| refFrame | input | $clog2(NUM_FRAMES) | Frame touched by the reference |
| fillValid | input | 1 | A frame was just loaded with a new page |
| fillFrame | input | $clog2(NUM_FRAMES) | Frame being initialised |
| victimReq | input | 1 | Ask for a replacement victim |
| victimValid | output | 1 | Victim result is present this cycle |
| victimFrame | output | $clog2(NUM_FRAMES) | Frame chosen for eviction |

## Verification
The aging registers cannot be seen directly at the ports, so a corrupted register shows up only as a wrong victim. It appears on the next request whose result depends on that frame's relative order, and it may stay hidden until that frame becomes a candidate minimum. The bench therefore runs directed sequences that drive chosen frames to the minimum, including full decay to zero and ties. It also runs a long random mix in which a reference model predicts every victim. A bad shift or a missed MSB set therefore shows up within a few requests.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftAll;   // reference event: shift every register
    logic setRef;     // set MSB of referenced frame
    logic loadFill;   // initialise filled frame
    logic capture;    // latch the minimum-tree result
  } ageCtrl_t;
endpackage

// File: rtl/lru_age_ctrl.sv
module lru_age_ctrl
  import lru_age_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     refValid,
  input  logic     fillValid,
  input  logic     victimReq,
  output ageCtrl_t ctrl,
  output logic     victimValid
);
  always_comb begin
    ctrl.shiftAll = refValid;
    ctrl.setRef   = refValid;
    ctrl.loadFill = fillValid;
    ctrl.capture  = victimReq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) victimValid <= 1'b0;
    else        victimValid <= victimReq;
  end
endmodule

// File: rtl/lru_age_datapath.sv
module lru_age_datapath
  import lru_age_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 8,
  localparam int IDXW      = $clog2(NUM_FRAMES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ageCtrl_t                    ctrl,
  input  logic [IDXW-1:0]             refFrame,
  input  logic [IDXW-1:0]             fillFrame,
  output logic [IDXW-1:0]             victimFrame,
  output logic [NUM_FRAMES*AGE_W-1:0] ageFlat
);
  localparam int LEAVES = 1 << IDXW;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam logic [AGE_W-1:0] FRESH = {1'b1, {(AGE_W-1){1'b0}}};

  logic [AGE_W-1:0] ageReg [NUM_FRAMES];

  // Per-frame aging registers
  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_frame
    localparam logic [IDXW-1:0] FIDX = IDXW'(f);
    always_ff @(posedge clk) begin
      if (!rst_n)
        ageReg[f] <= '0;
      else if (ctrl.loadFill && fillFrame == FIDX)
        ageReg[f] <= FRESH;
      else if (ctrl.shiftAll)
        ageReg[f] <= {ctrl.setRef && refFrame == FIDX, ageReg[f][AGE_W-1:1]};
    end
    assign ageFlat[f*AGE_W +: AGE_W] = ageReg[f];
  end

  // Minimum tree: heap layout, leaves at LEAVES-1 .. NODES-1
  logic [AGE_W-1:0] nodeAge [NODES];
  logic [IDXW-1:0]  nodeIdx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_FRAMES) begin : g_real
      assign nodeAge[LEAVES-1+i] = ageReg[i];
    end else begin : g_pad
      assign nodeAge[LEAVES-1+i] = '1;
    end
    assign nodeIdx[LEAVES-1+i] = IDXW'(i);
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
    logic pickLeft;
    // left subtree holds lower frame numbers; ties go left
    assign pickLeft   = nodeAge[2*n+1] <= nodeAge[2*n+2];
    assign nodeAge[n] = pickLeft ? nodeAge[2*n+1] : nodeAge[2*n+2];
    assign nodeIdx[n] = pickLeft ? nodeIdx[2*n+1] : nodeIdx[2*n+2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            victimFrame <= '0;
    else if (ctrl.capture) victimFrame <= nodeIdx[0];
  end
endmodule

// File: rtl/aging_lru_picker.sv
module aging_lru_picker
  import lru_age_pkg::*;
#(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 8,
  localparam int IDXW      = $clog2(NUM_FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refValid,
  input  logic [IDXW-1:0] refFrame,
  input  logic            fillValid,
  input  logic [IDXW-1:0] fillFrame,
  input  logic            victimReq,
  output logic            victimValid,
  output logic [IDXW-1:0] victimFrame
);
  ageCtrl_t                    ctrl;
  logic [NUM_FRAMES*AGE_W-1:0] ageFlat;

  lru_age_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .refValid    (refValid),
    .fillValid   (fillValid),
    .victimReq   (victimReq),
    .ctrl        (ctrl),
    .victimValid (victimValid)
  );

  lru_age_datapath #(
    .NUM_FRAMES (NUM_FRAMES),
    .AGE_W      (AGE_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .refFrame    (refFrame),
    .fillFrame   (fillFrame),
    .victimFrame (victimFrame),
    .ageFlat     (ageFlat)
  );
endmodule

// File: rtl/aging_lru_picker_chk.sv
module aging_lru_picker_chk #(
  parameter int NUM_FRAMES = 8,
  parameter int AGE_W      = 8,
  localparam int IDXW      = $clog2(NUM_FRAMES)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        refValid,
  input logic [IDXW-1:0]             refFrame,
  input logic                        fillValid,
  input logic [IDXW-1:0]             fillFrame,
  input logic                        victimReq,
  input logic                        victimValid,
  input logic [IDXW-1:0]             victimFrame,
  input logic [NUM_FRAMES*AGE_W-1:0] ageFlat
);
  localparam logic [AGE_W-1:0] FRESH = {1'b1, {(AGE_W-1){1'b0}}};

  p_valid_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    victimReq |=> victimValid);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !victimReq |=> !victimValid);
  p_victim_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> (32'(victimFrame) < NUM_FRAMES));
  p_ref_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (refValid && !(fillValid && fillFrame == refFrame))
      |=> ageFlat[$past(refFrame)*AGE_W + AGE_W-1]);
  p_fill_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |=> ageFlat[$past(fillFrame)*AGE_W +: AGE_W] == FRESH);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!refValid && !fillValid) |=> $stable(ageFlat));

  for (genvar f = 0; f < NUM_FRAMES; f++) begin : g_shift
    p_shift_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (refValid && refFrame != IDXW'(f) && !(fillValid && fillFrame == IDXW'(f)))
        |=> ageFlat[f*AGE_W +: AGE_W] == ($past(ageFlat[f*AGE_W +: AGE_W]) >> 1));
  end
endmodule

bind aging_lru_picker aging_lru_picker_chk #(
  .NUM_FRAMES (NUM_FRAMES),
  .AGE_W      (AGE_W)
) u_chk (.*);

// File: tb/aging_lru_picker_bench.sv
module aging_lru_picker_bench;
  localparam int NF   = 6;
  localparam int AW   = 4;
  localparam int IW   = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          refValid = 1'b0;
  logic [IW-1:0] refFrame = '0;
  logic          fillValid = 1'b0;
  logic [IW-1:0] fillFrame = '0;
  logic          victimReq = 1'b0;
  logic          victimValid;
  logic [IW-1:0] victimFrame;

  aging_lru_picker #(.NUM_FRAMES(NF), .AGE_W(AW)) u_aging_lru_picker (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .refFrame(refFrame),
    .fillValid(fillValid), .fillFrame(fillFrame), .victimReq(victimReq),
    .victimValid(victimValid), .victimFrame(victimFrame));

  always #10 clk = ~clk;  // 50 MHz

  int    testsRun = 0;
  int    testsFail = 0;
  int    expQ[$];
  string tagQ[$];
  logic [AW-1:0] model [NF];
  bit    started = 0;

  function automatic int modelMin();
    int best = 0;
    for (int f = 1; f < NF; f++) if (model[f] < model[best]) best = f;
    return best;
  endfunction

  task automatic step(input bit r, input int rf, input bit fl, input int ff,
                      input bit q, input string tag);
    @(negedge clk);
    refValid = r; refFrame = IW'(rf);
    fillValid = fl; fillFrame = IW'(ff);
    victimReq = q;
    if (q) begin expQ.push_back(modelMin()); tagQ.push_back(tag); end
    @(posedge clk);
    if (r) begin
      for (int f = 0; f < NF; f++) model[f] = model[f] >> 1;
      model[rf][AW-1] = 1'b1;
    end
    if (fl) model[ff] = {1'b1, {(AW-1){1'b0}}};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, "");
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (victimValid) begin
        testsRun++;
        if (expQ.size() == 0) begin
          testsFail++;
          $display("FAIL R7: victimValid with no request, actual frame %0d expected none", victimFrame);
        end else begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (int'(victimFrame) != e) begin
            testsFail++;
            $display("FAIL %s: victim actual %0d expected %0d", t, victimFrame, e);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #4000000;
    testsRun++; testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    for (int f = 0; f < NF; f++) model[f] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    testsRun++;  // R1 reset state
    if (victimValid !== 1'b0 || victimFrame !== '0) begin
      testsFail++;
      $display("FAIL R1: after reset valid=%0b frame=%0d expected valid=0 frame=0", victimValid, victimFrame);
    end
    started = 1;

    step(0, 0, 0, 0, 1, "R1");           // all zero, tie -> frame 0 (R6)
    step(1, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 1, "R3");           // frame 0 referenced -> frame 1
    for (int f = 0; f < NF; f++) step(1, f, 0, 0, 0, "");
    step(0, 0, 0, 0, 1, "R2");           // oldest reference frame 0
    for (int i = 0; i < AW + 1; i++) step(1, 4, 0, 0, 0, "");
    step(0, 0, 0, 0, 1, "R6");           // others decayed to zero -> 0
    step(0, 0, 1, 0, 0, "");
    step(0, 0, 1, 1, 0, "");
    step(0, 0, 0, 0, 1, "R4");           // fill 0,1 -> frame 2
    step(1, 2, 1, 2, 0, "");             // fill overrides ref on same frame
    step(1, 3, 0, 0, 1, "R7");           // request sees pre-update ages
    step(0, 0, 0, 0, 1, "R4");
    step(1, 5, 0, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R5");
    idle(2);

    for (int i = 0; i < 400; i++) begin
      bit r, fl, q;
      r  = ($urandom % 4) != 0;
      fl = ($urandom % 6) == 0;
      q  = ($urandom % 3) == 0;
      step(r, $urandom % NF, fl, $urandom % NF, q, "R5");
    end
    idle(3);

    testsRun++;  // every request answered exactly once
    if (expQ.size() != 0) begin
      testsFail++;
      $display("FAIL R7: pending results actual %0d expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end
endmodule